// File: doc/BRIEF.md
# Banked Data-Memory Address Generator

This block turns the file-register fields of an 8-bit core's instructions into physical addresses for a banked data memory with two ports. A file field of 7 bits normally selects a location inside the current bank. The two bank-select bits held in the block's status copy are placed in front of it to form a 9-bit address. File field 0 names no real location. It is a virtual pointer register: any access to it is sent through the 8-bit file-select register. One more high bank bit is placed above that register to form the 9-bit address.

The block owns the file-select register and the three bank bits. It watches the result write of the core. When that write lands on the file-select register or on the status register, it updates its copy, and the new value steers addresses from the next cycle on. The read port and the write port are resolved separately, so an operand read for one instruction and a result write for an earlier instruction can use the memory in the same cycle. A pointer that resolves back to the virtual register is caught on each port. A read of it returns zero without strobing the memory. A write to it is dropped.

The memory read port is taken to be asynchronous: `mem_rdata` is valid in the same cycle as `rd_addr`.

Top module: `dm_addr_gen`

## Requirements
- R1: When `rd_file`/`wr_file` is nonzero, the port address is {bank pair, file field}: bits 8:7 are the bank pair and bits 6:0 are the file field.
- R2: When the file field is 0, the port address is {high bank bit, pointer}: bit 8 is the high bank bit and bits 7:0 are the 8-bit file-select value.
- R3: An indirect read whose pointer has bits 6:0 equal to 0 keeps `rd_en` low and drives `op_rdata` to 0x00 whatever `mem_rdata` carries.
- R4: An indirect write whose pointer has bits 6:0 equal to 0 keeps `wr_en` low, and the write changes neither the pointer nor the bank bits.
- R5: The read and write ports are resolved independently in the same cycle, each from its own file field and request.
- R6: An enabled write whose resolved address has bits 6:0 equal to 0x04, in any bank, loads `wr_data` into the file-select register. The new value is used from the next cycle, not in the cycle of the write.
- R7: An enabled write whose resolved address has bits 6:0 equal to 0x03, in any bank, loads `wr_data[7]` as the high bank bit and `wr_data[6:5]` as the bank pair. The other data bits are ignored. The new values are used from the next cycle.
- R8: Reset is synchronous and active low. While `rst_n` is low both strobes are low. After reset the pointer and all bank bits are 0.
- R9: When the read is not self-referencing, `op_rdata` equals `mem_rdata`.
- R10: When a port is not self-referencing, its strobe follows its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | The operand read of this cycle uses data memory |
| rd_file | input | 7 | File field of the operand read |
| wr_req | input | 1 | The result write of this cycle targets data memory |
| wr_file | input | 7 | File field of the result write |
| wr_data | input | 8 | Result data being written |
| mem_rdata | input | 8 | Data from the memory read port |
| rd_addr | output | 9 | Memory read address |
| rd_en | output | 1 | Memory read strobe |
| wr_addr | output | 9 | Memory write address |
| wr_en | output | 1 | Memory write strobe |
| op_rdata | output | 8 | Operand delivered to the core |

## Verification
The two functions that share a cycle are the operand read and the result write. The case that matters is a write that reloads the pointer or the bank bits while the read in that same cycle goes indirect or into a bank. The bench provokes this by biasing both file fields toward 0, 0x03 and 0x04, and by biasing the write data toward pointer values whose low seven bits are zero. The read in the cycle of the update must still use the old pointer and bank bits, and the read one cycle later must use the new ones. A behavioural model compares both addresses, both strobes and the operand on every clock.

// File: rtl/dmag_pkg.sv
// Shared constants and types of the banked data-memory address generator.
// Assumes an 8-bit pointer, a 7-bit file field and a two-bit bank pair,
// so that direct and indirect addresses come out the same width.
package dmag_pkg;
    localparam int DATA_W  = 8;
    localparam int FILE_W  = 7;
    localparam int RP_W    = 2;
    localparam int IRP_W   = 1;
    localparam int ADDR_W  = RP_W + FILE_W;
    localparam int FA_VIRT = 0;
    localparam int FA_STAT = 3;
    localparam int FA_PTR  = 4;
    localparam int IRP_POS = 7;
    localparam int RP_LSB  = 5;

    typedef struct packed {
        logic [IRP_W-1:0] irp;
        logic [RP_W-1:0]  rp;
    } bank_sel_t;
endpackage

// File: rtl/dmag_resolve.sv
// Address resolver for one memory port. A nonzero file field is placed
// behind the bank pair. File field 0 redirects through the pointer, with
// the high bank bit in front. Flags the case where the pointer leads back
// to the virtual register. Assumes IRP_W + DATA_W == ADDR_W.
module dmag_resolve
    import dmag_pkg::*;
(
    input  logic [FILE_W-1:0] file_sel,
    input  logic [DATA_W-1:0] ptr,
    input  bank_sel_t         bank,
    output logic [ADDR_W-1:0] addr,
    output logic              self_ref
);
    logic via_ptr;

    // Choose the direct or the redirected address.
    always_comb begin
        via_ptr  = (file_sel == FILE_W'(FA_VIRT));
        addr     = via_ptr ? {bank.irp, ptr} : {bank.rp, file_sel};
        self_ref = via_ptr && (ptr[FILE_W-1:0] == FILE_W'(FA_VIRT));
    end
endmodule

// File: rtl/dmag_regs.sv
// Holds the file-select pointer and the bank-select bits. They are loaded
// when an enabled write resolves to their file slot in any bank.
// Assumes wr_slot is the low file bits of the resolved write address.
module dmag_regs
    import dmag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FILE_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ptr_q,
    output bank_sel_t         bank_q
);
    logic hit_ptr, hit_stat;

    // Decode which held register the current write lands on.
    always_comb begin
        hit_ptr  = wr_en && (wr_slot == FILE_W'(FA_PTR));
        hit_stat = wr_en && (wr_slot == FILE_W'(FA_STAT));
    end

    // Load the pointer and the bank bits, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            bank_q <= '0;
        end else begin
            if (hit_ptr)
                ptr_q <= wr_data;
            if (hit_stat) begin
                bank_q.irp <= wr_data[IRP_POS -: IRP_W];
                bank_q.rp  <= wr_data[RP_LSB +: RP_W];
            end
        end
    end

    // R6
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == FILE_W'(FA_PTR)) |=> (ptr_q == $past(wr_data)));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_slot == FILE_W'(FA_PTR)) |=> $stable(ptr_q));

    // R7
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == FILE_W'(FA_STAT)) |=>
        (bank_q.rp == $past(wr_data[RP_LSB +: RP_W]) &&
         bank_q.irp == $past(wr_data[IRP_POS -: IRP_W])));
endmodule

// File: rtl/dm_addr_gen.sv
// Top of the banked data-memory address generator. Resolves the read port
// and the write port with one resolver each, gates the strobes, returns
// zero for a self-referencing read, and keeps the pointer and bank bits.
// Assumes a memory whose read data is valid in the cycle of its address.
module dm_addr_gen
    import dmag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [FILE_W-1:0] rd_file,
    input  logic              wr_req,
    input  logic [FILE_W-1:0] wr_file,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] op_rdata
);
    localparam int NPORT = 2;

    logic [DATA_W-1:0] ptr_q;
    bank_sel_t         bank_q;
    logic [FILE_W-1:0] port_file [NPORT];
    logic [ADDR_W-1:0] port_addr [NPORT];
    logic [NPORT-1:0]  port_self;

    assign port_file[0] = rd_file;
    assign port_file[1] = wr_file;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dmag_resolve u_res (
            .file_sel (port_file[p]),
            .ptr      (ptr_q),
            .bank     (bank_q),
            .addr     (port_addr[p]),
            .self_ref (port_self[p])
        );
    end

    // Drive the port addresses, gated strobes and the operand.
    always_comb begin
        rd_addr  = port_addr[0];
        wr_addr  = port_addr[1];
        rd_en    = rst_n && rd_req && !port_self[0];
        wr_en    = rst_n && wr_req && !port_self[1];
        op_rdata = port_self[0] ? '0 : mem_rdata;
    end

    dmag_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_addr[FILE_W-1:0]),
        .wr_data (wr_data),
        .ptr_q   (ptr_q),
        .bank_q  (bank_q)
    );

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!rd_en && !wr_en));

    // R3
    rd_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_file == FILE_W'(FA_VIRT) && rd_addr[FILE_W-1:0] == FILE_W'(FA_VIRT))
        |-> (!rd_en && op_rdata == '0));

    // R4
    wr_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_file == FILE_W'(FA_VIRT) && wr_addr[FILE_W-1:0] == FILE_W'(FA_VIRT))
        |-> !wr_en);

    // R1
    direct_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_file != FILE_W'(FA_VIRT)) |-> (rd_addr[FILE_W-1:0] == rd_file && rd_en == rd_req));

    // R7
    bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_file != FILE_W'(FA_VIRT) && $past(wr_en && wr_addr[FILE_W-1:0] == FILE_W'(FA_STAT)))
        |-> (rd_addr[ADDR_W-1 -: RP_W] == $past(wr_data[RP_LSB +: RP_W])));
endmodule

// File: tb/dm_addr_gen_tb.sv
`timescale 1ns/1ps
module dm_addr_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req = 1'b0, wr_req = 1'b0;
    logic [6:0] rd_file = '0, wr_file = '0;
    logic [7:0] wr_data = '0, mem_rdata = '0;
    logic [8:0] rd_addr, wr_addr;
    logic       rd_en, wr_en;
    logic [7:0] op_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference state, kept as plain values.
    logic [7:0] m_ptr = '0;
    logic       m_hi = 1'b0;
    logic [1:0] m_pair = '0;
    bit prev_ptr_upd = 1'b0, prev_bank_upd = 1'b0;

    always #2 clk = ~clk;

    dm_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_file(rd_file),
        .wr_req(wr_req), .wr_file(wr_file), .wr_data(wr_data),
        .mem_rdata(mem_rdata), .rd_addr(rd_addr), .rd_en(rd_en),
        .wr_addr(wr_addr), .wr_en(wr_en), .op_rdata(op_rdata)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] resolve(input logic [6:0] f);
        return (f == 7'd0) ? {m_hi, m_ptr} : {m_pair, f};
    endfunction

    task automatic step(input bit rst, input bit rr, input logic [6:0] rf,
                        input bit wr, input logic [6:0] wf,
                        input logic [7:0] wd, input logic [7:0] md);
        logic [8:0] e_ra, e_wa;
        bit r_self, w_self, e_re, e_we;
        string atag;
        @(negedge clk);
        rst_n = rst; rd_req = rr; rd_file = rf; wr_req = wr; wr_file = wf;
        wr_data = wd; mem_rdata = md;
        #1;
        if (!rst) begin
            chk("R8", "rd_en in reset", rd_en, 0);
            chk("R8", "wr_en in reset", wr_en, 0);
            m_ptr = '0; m_hi = 1'b0; m_pair = '0;
            prev_ptr_upd = 0; prev_bank_upd = 0;
            return;
        end
        e_ra   = resolve(rf);
        e_wa   = resolve(wf);
        r_self = (rf == 0) && (m_ptr[6:0] == 0);
        w_self = (wf == 0) && (m_ptr[6:0] == 0);
        e_re   = rr && !r_self;
        e_we   = wr && !w_self;
        if (rf == 0 && prev_ptr_upd) atag = "R6";
        else if (prev_bank_upd) atag = "R7";
        else atag = (rf == 0) ? "R2" : "R1";
        chk(atag, "rd_addr", rd_addr, e_ra);
        chk((wf == 0) ? "R2" : "R1", "wr_addr", wr_addr, e_wa);
        chk(r_self ? "R3" : "R10", "rd_en", rd_en, e_re);
        chk(w_self ? "R4" : "R10", "wr_en", wr_en, e_we);
        chk(r_self ? "R3" : "R9", "op_rdata", op_rdata, r_self ? 8'h00 : md);
        if (rr && wr)
            chk("R5", "both ports", {rd_addr, wr_addr, rd_en, wr_en}, {e_ra, e_wa, e_re, e_we});
        prev_ptr_upd = 0; prev_bank_upd = 0;
        if (e_we && e_wa[6:0] == 7'd4) begin m_ptr = wd; prev_ptr_upd = 1; end
        if (e_we && e_wa[6:0] == 7'd3) begin m_hi = wd[7]; m_pair = wd[6:5]; prev_bank_upd = 1; end
    endtask

    function automatic logic [6:0] pick_file();
        case ($urandom % 5)
            0: return 7'd0;
            1: return 7'd3;
            2: return 7'd4;
            3: return 7'h7f;
            default: return 7'($urandom);
        endcase
    endfunction

    function automatic logic [7:0] pick_data();
        case ($urandom % 3)
            0: return 8'($urandom) & 8'h80;
            1: return 8'($urandom) & 8'hE4;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        // R8: strobes stay low under reset even with requests raised
        repeat (3) step(0, 1, 7'd5, 1, 7'd0, 8'h11, 8'h22);
        // R3/R4: pointer starts at 0, so both ports are self-referencing
        step(1, 1, 7'd0, 1, 7'd0, 8'h55, 8'hA5);
        // R4: the dropped write must not have moved the pointer
        step(1, 1, 7'd0, 0, 7'd0, 8'h00, 8'h3C);
        // R6/R5: pointer load while an indirect read uses the old value
        step(1, 1, 7'd0, 1, 7'd4, 8'hA7, 8'h99);
        step(1, 1, 7'd0, 0, 7'd0, 8'h00, 8'h42);
        // R7: bank bits come from data bits 7 and 6:5 only
        step(1, 1, 7'd10, 1, 7'd3, 8'hDF, 8'h01);
        step(1, 1, 7'd10, 1, 7'd0, 8'h33, 8'h02);
        // R6: an indirect write to a mirrored pointer slot reloads the pointer
        step(1, 0, 7'd0, 1, 7'd4, 8'h84, 8'h00);
        step(1, 1, 7'd0, 1, 7'd0, 8'h80, 8'h77);
        step(1, 1, 7'd0, 1, 7'd0, 8'h12, 8'h66);
        for (int i = 0; i < 4000; i++) begin
            step((i % 1500) != 1499, ($urandom % 4) != 0, pick_file(),
                 ($urandom % 4) != 0, pick_file(), pick_data(), 8'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule